// File: doc/BRIEF.md
# Overcurrent Fault Supervisor with Timed Auto-Clear

This block watches a digital overcurrent trip flag and the supply-good flags of a three-leg half-bridge gate driver. It decides when the six gate outputs may follow their commands. A trip that lasts longer than a short blanking window is captured in a latch where setting wins over clearing. The latch forces all outputs off and pulls the active-low fault flag down. The latch releases only after the trip has been absent for a programmable number of clock cycles. Any trip activity during that wait discharges the timer and restarts it.

A low-side supply undervoltage also forces every output off and reports a fault. It is not latched, so the fault flag follows the supply flag. An undervoltage on one leg's floating high-side supply only blocks that leg's high-side output and reports nothing. The enable input gates the outputs but never touches the fault flag.

Top module: `oc_fault_supervisor`

## Requirements
- R1: While reset is held, and until a clock edge after reset has sampled `vlow_good_i` high, `shutdown_o` is 1, `fault_n_o` is 0 and all six drive outputs are 0.
- R2: A trip (`oc_trip_i` = 1) seen on BLANK_CYC or fewer consecutive clock edges sets nothing: `fault_n_o` stays 1 and `shutdown_o` stays 0.
- R3: A trip seen on BLANK_CYC+1 consecutive edges sets the fault latch at that edge. From then on `shutdown_o` = 1, `fault_n_o` = 0 and every drive output is 0.
- R4: While the trip stays active, the latch stays set for any duration, including durations longer than CLEAR_CYC.
- R5: Counting the first edge that samples the trip low as edge 1, the latch releases at edge CLEAR_CYC. It is still set after edge CLEAR_CYC-1.
- R6: Any edge that samples the trip high during the countdown, even a single edge inside the blanking window, resets the count to zero. The CLEAR_CYC edges are then counted again from the next edge that samples the trip low.
- R7: One edge after `vlow_good_i` is sampled low, `shutdown_o` = 1, `fault_n_o` = 0 and all outputs are 0. One edge after it is sampled high again, both flags release without waiting for the clear count.
- R8: A low bit i of `vhigh_good_i` forces `hi_drv_o[i]` to 0 at once. It leaves `lo_drv_o[i]`, `fault_n_o` and `shutdown_o` unchanged.
- R9: `en_i` = 0 forces all six outputs to 0 at once. It has no effect on `fault_n_o`, `shutdown_o` or the clear timing.
- R10: With no fault, `en_i` = 1 and every supply good, `hi_drv_o` equals `hi_cmd_i` and `lo_drv_o` equals `lo_cmd_i`, bit i being leg i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_trip_i | input | 1 | Overcurrent comparator flag, 1 = overcurrent |
| vlow_good_i | input | 1 | Low-side supply good, hysteresis already applied |
| vhigh_good_i | input | NUM_LEGS | Per-leg floating supply good |
| en_i | input | 1 | Output enable, 1 = outputs may follow commands |
| hi_cmd_i | input | NUM_LEGS | High-side commands, bit i = leg i |
| lo_cmd_i | input | NUM_LEGS | Low-side commands, bit i = leg i |
| hi_drv_o | output | NUM_LEGS | Gated high-side drive |
| lo_drv_o | output | NUM_LEGS | Gated low-side drive |
| shutdown_o | output | 1 | Global shutdown, 1 = all outputs forced off |
| fault_n_o | output | 1 | Fault flag, 0 = overcurrent latched or low-side undervoltage |

## Verification
The bench sweeps trip pulse lengths across the blanking boundary. An off-by-one filter would latch a BLANK_CYC pulse or miss a BLANK_CYC+1 pulse. It measures the release edge exactly, which exposes a timer that counts CLEAR_CYC±1. It also retriggers the trip during the countdown, including on the very edge that would have released the latch. A timer that keeps running through trip activity, or that lets a clear beat a set, then releases early. Finally, it exhaustively crosses enable, per-leg supply flags and commands. This catches leaks between high-side and low-side gating, and catches an enable that disturbs the fault flag.

// File: rtl/oc_fault_pkg.sv
`timescale 1ns/1ps
package oc_fault_pkg;

  // Bits needed to hold values 0..limit.
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // A trip run has outlasted the blanking window once it reaches the limit.
  function automatic logic blank_met(input int unsigned run, input int unsigned limit);
    return run >= limit;
  endfunction

  // The clear countdown ends on the edge whose pre-edge count is limit-1.
  function automatic logic clear_expired(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

endpackage

// File: rtl/oc_blank_filter.sv
`timescale 1ns/1ps
module oc_blank_filter #(
  parameter int BLANK_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  output logic qual_o
);
  localparam int RW = oc_fault_pkg::cnt_width(BLANK_CYC);

  logic [RW-1:0] run_q;
  logic          met;

  assign met = oc_fault_pkg::blank_met(32'(run_q), BLANK_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (!trip_i) run_q <= '0;
    else if (!met)    run_q <= run_q + RW'(1);
  end

  // Qualified only while the trip is still present after the window.
  assign qual_o = trip_i && met;
endmodule

// File: rtl/oc_fault_latch.sv
`timescale 1ns/1ps
module oc_fault_latch #(
  parameter int CLEAR_CYC = 330000,
  parameter int CNT_W     = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             trip_i,
  output logic             latched_o,
  output logic [CNT_W-1:0] clr_cnt_o,
  output logic             release_o
);
  logic             latched_q;
  logic [CNT_W-1:0] cnt_q;
  logic             timer_run;

  // Timer is held discharged unless latched with the trip gone.
  assign timer_run = latched_q && !trip_i;
  assign release_o = timer_run && oc_fault_pkg::clear_expired(32'(cnt_q), CLEAR_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!timer_run) cnt_q <= '0;
    else if (release_o)  cnt_q <= '0;
    else                 cnt_q <= cnt_q + CNT_W'(1);
  end

  // Set has priority over the timed release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latched_q <= 1'b0;
    else if (set_i)     latched_q <= 1'b1;
    else if (release_o) latched_q <= 1'b0;
  end

  assign latched_o = latched_q;
  assign clr_cnt_o = cnt_q;
endmodule

// File: rtl/oc_leg_gate.sv
`timescale 1ns/1ps
module oc_leg_gate (
  input  logic hi_cmd_i,
  input  logic lo_cmd_i,
  input  logic allow_i,
  input  logic hs_good_i,
  output logic hi_drv_o,
  output logic lo_drv_o
);
  assign hi_drv_o = hi_cmd_i && allow_i && hs_good_i;
  assign lo_drv_o = lo_cmd_i && allow_i;
endmodule

// File: rtl/oc_fault_supervisor.sv
`timescale 1ns/1ps
module oc_fault_supervisor #(
  parameter int NUM_LEGS  = 3,
  parameter int BLANK_CYC = 24,
  parameter int CLEAR_CYC = 330000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                oc_trip_i,
  input  logic                vlow_good_i,
  input  logic [NUM_LEGS-1:0] vhigh_good_i,
  input  logic                en_i,
  input  logic [NUM_LEGS-1:0] hi_cmd_i,
  input  logic [NUM_LEGS-1:0] lo_cmd_i,
  output logic [NUM_LEGS-1:0] hi_drv_o,
  output logic [NUM_LEGS-1:0] lo_drv_o,
  output logic                shutdown_o,
  output logic                fault_n_o
);
  localparam int CNT_W = oc_fault_pkg::cnt_width(CLEAR_CYC);

  // Named internal events, visible to the bound checker.
  logic             oc_qual;
  logic             fault_latched;
  logic [CNT_W-1:0] clr_cnt;
  logic             clr_release;
  logic             lv_ok_q;
  logic             drive_allow;

  oc_blank_filter #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk    (clk),
    .rst_n  (rst_n),
    .trip_i (oc_trip_i),
    .qual_o (oc_qual)
  );

  oc_fault_latch #(.CLEAR_CYC(CLEAR_CYC), .CNT_W(CNT_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (oc_qual),
    .trip_i    (oc_trip_i),
    .latched_o (fault_latched),
    .clr_cnt_o (clr_cnt),
    .release_o (clr_release)
  );

  // Low-side supply flag, sampled; held bad through reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lv_ok_q <= 1'b0;
    else        lv_ok_q <= vlow_good_i;
  end

  assign shutdown_o  = fault_latched || !lv_ok_q;
  assign fault_n_o   = !(fault_latched || !lv_ok_q);
  assign drive_allow = en_i && !shutdown_o;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    oc_leg_gate u_gate (
      .hi_cmd_i  (hi_cmd_i[g]),
      .lo_cmd_i  (lo_cmd_i[g]),
      .allow_i   (drive_allow),
      .hs_good_i (vhigh_good_i[g]),
      .hi_drv_o  (hi_drv_o[g]),
      .lo_drv_o  (lo_drv_o[g])
    );
  end
endmodule

// File: rtl/oc_fault_checker.sv
`timescale 1ns/1ps
module oc_fault_checker #(
  parameter int NUM_LEGS  = 3,
  parameter int CLEAR_CYC = 330000,
  parameter int CNT_W     = 19
) (
  input logic                clk,
  input logic                rst_n,
  input logic                oc_trip_i,
  input logic                vlow_good_i,
  input logic [NUM_LEGS-1:0] vhigh_good_i,
  input logic [NUM_LEGS-1:0] hi_drv_o,
  input logic [NUM_LEGS-1:0] lo_drv_o,
  input logic                shutdown_o,
  input logic                fault_n_o,
  input logic                oc_qual,
  input logic                fault_latched,
  input logic [CNT_W-1:0]    clr_cnt
);
  a_r3_outputs_dark: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |-> (hi_drv_o == '0 && lo_drv_o == '0));

  a_r3_qual_sets: assert property (@(posedge clk) disable iff (!rst_n)
    oc_qual |=> fault_latched);

  a_r2_set_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> $past(oc_qual));

  a_r4_hold_during_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && oc_trip_i) |=> fault_latched);

  a_r5_release_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_latched) |-> ($past(clr_cnt) == CNT_W'(CLEAR_CYC - 1) && !$past(oc_trip_i)));

  a_r6_timer_discharged: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip_i |=> (clr_cnt == '0));

  a_r7_low_uv_reported: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vlow_good_i) |-> (!fault_n_o && shutdown_o));

  a_r8_hs_uv_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_drv_o & ~vhigh_good_i) == '0);

  a_r9_flag_matches_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n_o == !shutdown_o);
endmodule

bind oc_fault_supervisor oc_fault_checker #(
  .NUM_LEGS (NUM_LEGS),
  .CLEAR_CYC(CLEAR_CYC),
  .CNT_W    (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .oc_trip_i    (oc_trip_i),
  .vlow_good_i  (vlow_good_i),
  .vhigh_good_i (vhigh_good_i),
  .hi_drv_o     (hi_drv_o),
  .lo_drv_o     (lo_drv_o),
  .shutdown_o   (shutdown_o),
  .fault_n_o    (fault_n_o),
  .oc_qual      (oc_qual),
  .fault_latched(fault_latched),
  .clr_cnt      (clr_cnt)
);

// File: tb/tb_oc_fault_supervisor.sv
`timescale 1ns/1ps
module tb_oc_fault_supervisor;
  localparam int LEGS = 3;
  localparam int BLK  = 3;
  localparam int CLR  = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, trip, vlow, en, shut, fault_n;
  logic [LEGS-1:0] vhigh, hi_cmd, lo_cmd, hi_drv, lo_drv;

  oc_fault_supervisor #(.NUM_LEGS(LEGS), .BLANK_CYC(BLK), .CLEAR_CYC(CLR)) dut (
    .clk(clk), .rst_n(rst_n), .oc_trip_i(trip), .vlow_good_i(vlow),
    .vhigh_good_i(vhigh), .en_i(en), .hi_cmd_i(hi_cmd), .lo_cmd_i(lo_cmd),
    .hi_drv_o(hi_drv), .lo_drv_o(lo_drv), .shutdown_o(shut), .fault_n_o(fault_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Latch a fault and drop the trip; returns with trip low, before edge 1.
  task automatic latch_fault();
    trip = 1'b1;
    edges(BLK + 2);
    chk("R3 latched", {31'd0, fault_n}, 0);
    trip = 1'b0;
  endtask

  // Expect release exactly on the CLR-th edge from now.
  task automatic expect_release(input string req);
    edges(CLR - 1);
    chk({req, " still held at CLR-1"}, {30'd0, fault_n, shut}, 32'b01);
    edges(1);
    chk({req, " released at CLR"}, {30'd0, fault_n, shut}, 32'b10);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trip = 1'b0; vlow = 1'b1; vhigh = '1; en = 1'b1;
    hi_cmd = '1; lo_cmd = '1;
    edges(3);
    // R1: reset state
    chk("R1 flags in reset", {30'd0, fault_n, shut}, 32'b01);
    chk("R1 outputs in reset", {26'd0, hi_drv, lo_drv}, 0);
    vlow = 1'b0;
    rst_n = 1'b1;
    edges(2);
    chk("R1 held until supply good", {30'd0, fault_n, shut}, 32'b01);
    vlow = 1'b1;
    edges(1);
    chk("R1 released after supply good", {30'd0, fault_n, shut}, 32'b10);
    chk("R10 passthrough", {26'd0, hi_drv, lo_drv}, 32'b111111);

    // R2/R3/R5: sweep pulse length across the blanking boundary
    hi_cmd = 3'b101; lo_cmd = 3'b010;
    for (int len = 1; len <= BLK + 3; len++) begin
      trip = 1'b1;
      for (int k = 1; k <= len; k++) begin
        edges(1);
        if (k >= BLK + 1) begin
          chk("R3 fault after blanking", {31'd0, fault_n}, 0);
          chk("R3 outputs off", {26'd0, hi_drv, lo_drv}, 0);
        end else begin
          chk("R2 blanked", {30'd0, fault_n, shut}, 32'b10);
        end
      end
      trip = 1'b0;
      if (len >= BLK + 1) begin
        for (int j = 1; j <= CLR; j++) begin
          edges(1);
          chk("R5 countdown", {31'd0, fault_n}, (j >= CLR) ? 1 : 0);
        end
      end else begin
        edges(2);
        chk("R2 no latch", {30'd0, fault_n, shut}, 32'b10);
        chk("R2 outputs follow", {26'd0, hi_drv, lo_drv}, 32'b101010);
      end
    end

    // R4: long trip holds the latch
    trip = 1'b1;
    for (int k = 1; k <= BLK + CLR + 6; k++) begin
      edges(1);
      if (k >= BLK + 1) chk("R4 held while trip", {31'd0, fault_n}, 0);
    end
    trip = 1'b0;
    expect_release("R5 after long trip");

    // R6: short retrigger mid-countdown
    latch_fault();
    edges(CLR / 2);
    trip = 1'b1;
    edges(1);
    trip = 1'b0;
    expect_release("R6 short retrigger");

    // R6: long retrigger mid-countdown
    latch_fault();
    edges(CLR / 2);
    trip = 1'b1;
    edges(BLK + 4);
    trip = 1'b0;
    expect_release("R6 long retrigger");

    // R6: retrigger on the edge that would have released
    latch_fault();
    edges(CLR - 1);
    trip = 1'b1;
    edges(1);
    chk("R6 set wins on release edge", {31'd0, fault_n}, 0);
    trip = 1'b0;
    expect_release("R6 late retrigger");

    // R7: low-side undervoltage, not latched
    vlow = 1'b0;
    edges(1);
    chk("R7 uv flags", {30'd0, fault_n, shut}, 32'b01);
    chk("R7 uv outputs off", {26'd0, hi_drv, lo_drv}, 0);
    edges(CLR + 5);
    chk("R7 uv persists", {30'd0, fault_n, shut}, 32'b01);
    vlow = 1'b1;
    edges(1);
    chk("R7 uv releases at once", {30'd0, fault_n, shut}, 32'b10);
    vlow = 1'b0;
    edges(1);
    vlow = 1'b1;
    chk("R7 one-edge uv", {31'd0, fault_n}, 0);
    edges(1);
    chk("R7 one-edge uv released", {31'd0, fault_n}, 1);

    // R9: enable does not touch the fault path or its timing
    latch_fault();
    en = 1'b0;
    edges(3);
    chk("R9 fault kept with en low", {31'd0, fault_n}, 0);
    en = 1'b1;
    edges(CLR - 4);
    en = 1'b0;
    chk("R9 still held", {31'd0, fault_n}, 0);
    edges(1);
    chk("R9 release unaffected", {30'd0, fault_n, shut}, 32'b10);
    chk("R9 outputs off with en low", {26'd0, hi_drv, lo_drv}, 0);
    en = 1'b1;

    // R8/R9/R10: exhaustive gating sweep, no fault present
    for (int e = 0; e < 2; e++) begin
      for (int g = 0; g < 8; g++) begin
        for (int h = 0; h < 8; h++) begin
          for (int l = 0; l < 8; l++) begin
            @(negedge clk);
            en = e[0]; vhigh = g[2:0]; hi_cmd = h[2:0]; lo_cmd = l[2:0];
            #1;
            chk("R8/R9/R10 gating", {24'd0, fault_n, shut, hi_drv, lo_drv},
                {24'd0, 1'b1, 1'b0, h[2:0] & g[2:0] & {3{e[0]}}, l[2:0] & {3{e[0]}}});
          end
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule